// File: doc/BRIEF.md
# Channel-Status Block Capture

This block gathers the channel-status bits carried by one full block of a digital audio interface stream (192 frames, one status bit per subframe) for a single chosen subchannel, and holds the finished block for software-style readout. Decoded subframes arrive on a valid/ready stream. Each subframe carries its status bit, a flag telling whether it belongs to subchannel A or B, and a marker that is set on the first frame of a block. The block never applies back-pressure: `sub_ready` stays high once reset is released, and a subframe counts only in a cycle where both `sub_valid` and `sub_ready` are high.

Incoming bits are placed into a staging register at the position of their frame within the block. When the next block-start marker arrives and exactly 192 frames have been collected, the staging register is copied in one edge to a readable buffer. Reads therefore always return bits from a single block. A block that is cut short, or abandoned by a change of the subchannel selection, never reaches the buffer.

The buffer is read as six 32-bit words. A 3-bit word select picks the word, and each word holds four consecutive status bytes with the lowest-numbered byte in the least significant position.

Top module: `cs_capture`

## Requirements
- R1: After reset the readable buffer and the staging register are all zero, so every `word_sel` value reads `rd_word` = 0, and `sub_ready` is 1.
- R2: Status bit k of a block (k = 0 for the frame with the block-start marker) is stored as status byte k/8, bit k%8. `rd_word[8j+7:8j]` holds status byte 4*`word_sel`+j for j = 0..3. `word_sel` values 6 and 7 read zero. `rd_word` is registered and follows `word_sel` and the buffer one clock later.
- R3: With `chan_sel` = 0, only subframes with `sub_is_b` = 0 are captured. With `chan_sel` = 1, only subframes with `sub_is_b` = 1 are captured. Subframes of the other subchannel, including their block-start markers, have no effect.
- R4: On an accepted block-start subframe of the selected subchannel, the buffer takes the staging contents in that same clock edge if exactly 192 frames of the selected subchannel have been collected since the previous start.
- R5: A block that receives a new block-start marker before 192 frames have been collected is discarded, and the buffer keeps its previous contents.
- R6: Selected subframes without a block-start marker are ignored when no block has started since reset, and also once 192 frames are held. Neither case disturbs the collected block.
- R7: A change of `chan_sel` abandons the block in progress. Frames are then ignored until the next block-start marker of the newly selected subchannel.
- R8: `sub_ready` is always 1 out of reset. Cycles with `sub_valid` = 0 have no effect, whatever the other subframe inputs show.
- R9: The buffer changes only in the clock edge of a commit (R4), so a read never mixes two blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_valid | input | 1 | Subframe present on the stream |
| sub_ready | output | 1 | Always 1 out of reset (no back-pressure) |
| sub_is_b | input | 1 | Subframe belongs to subchannel B (0 = A) |
| sub_blk_start | input | 1 | Subframe belongs to frame 0 of a block |
| sub_cs_bit | input | 1 | Channel-status bit of this subframe |
| chan_sel | input | 1 | Subchannel to capture (0 = A, 1 = B) |
| word_sel | input | 3 | Readout word (0..5, 6 and 7 read zero) |
| rd_word | output | 32 | Four status bytes of the selected word |

## Verification
A commit happens in the clock edge that accepts the block-start subframe. `rd_word` shows it one edge later, and it shows a new `word_sel` value one edge after the select changes. The bench drives all inputs on the falling edge. For each readout it sets `word_sel` on one falling edge and samples on the next, so exactly one rising edge has passed. Every commit is complete at least one rising edge before the first read that depends on it. Discard cases (short block, subchannel change, stray frames, idle cycles) are checked by reading the whole buffer back after the next block-start marker. A wrongful commit would show up in that readback.

// File: rtl/cs_capture_pkg.sv
package cs_capture_pkg;

  // Default block geometry
  localparam int unsigned BLOCK_FRAMES = 192;
  localparam int unsigned READ_WIDTH   = 32;
  localparam int unsigned SELECT_WIDTH = 3;

  // One decoded subframe as seen by the capture logic
  typedef struct packed {
    logic is_b;
    logic blk_start;
    logic cs_bit;
  } subframe_t;

endpackage

// File: rtl/cs_frame_tracker.sv
module cs_frame_tracker
  import cs_capture_pkg::*;
#(
  parameter int unsigned FRAMES = BLOCK_FRAMES,
  localparam int unsigned IDX_W = $clog2(FRAMES),
  localparam int unsigned CNT_W = $clog2(FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  subframe_t        sub,
  input  logic             chan_sel,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_bit,
  output logic             commit,
  output logic [CNT_W-1:0] frame_cnt
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAMES);

  logic             chan_prev;
  logic             chan_flip;
  logic             hit;
  logic [CNT_W-1:0] cnt_nxt;

  assign chan_flip = (chan_sel != chan_prev);
  assign hit       = accept && (sub.is_b == chan_sel);
  assign wr_bit    = sub.cs_bit;

  // frame_cnt = 0 : no block in progress
  // frame_cnt = n : frames 0..n-1 of the current block are staged
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = '0;
    commit  = 1'b0;
    cnt_nxt = frame_cnt;
    if (chan_flip) begin
      cnt_nxt = '0;
    end else if (hit && sub.blk_start) begin
      commit  = (frame_cnt == FULL);
      wr_en   = 1'b1;
      wr_idx  = '0;
      cnt_nxt = CNT_W'(1);
    end else if (hit && (frame_cnt != '0) && (frame_cnt < FULL)) begin
      wr_en   = 1'b1;
      wr_idx  = IDX_W'(frame_cnt);
      cnt_nxt = frame_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      chan_prev <= 1'b0;
    end else begin
      frame_cnt <= cnt_nxt;
      chan_prev <= chan_sel;
    end
  end

endmodule

// File: rtl/cs_stage_reg.sv
module cs_stage_reg #(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned IDX_W = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [FRAMES-1:0] stage
);

  // One enable per bit position: each frame lands at its own index
  for (genvar g = 0; g < FRAMES; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        stage[g] <= wr_bit;
      end
    end
  end

endmodule

// File: rtl/cs_read_port.sv
module cs_read_port #(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned NUM_WORDS = FRAMES / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [FRAMES-1:0] stage,
  input  logic [SEL_W-1:0]  word_sel,
  output logic [FRAMES-1:0] held,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] word_arr [NUM_WORDS];
  logic [WORD_W-1:0] pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (commit) begin
      held <= stage;
    end
  end

  // Word w holds bits 32w..32w+31: byte j of word w is status byte 4w+j
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_arr[w] = held[w*WORD_W +: WORD_W];
  end

  always_comb begin
    pick = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_sel == SEL_W'(w)) pick = word_arr[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '0;
    end else begin
      rd_word <= pick;
    end
  end

endmodule

// File: rtl/cs_capture.sv
module cs_capture
  import cs_capture_pkg::*;
#(
  parameter int unsigned FRAMES = BLOCK_FRAMES,
  parameter int unsigned WORD_W = READ_WIDTH,
  parameter int unsigned SEL_W  = SELECT_WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_valid,
  output logic              sub_ready,
  input  logic              sub_is_b,
  input  logic              sub_blk_start,
  input  logic              sub_cs_bit,
  input  logic              chan_sel,
  input  logic [SEL_W-1:0]  word_sel,
  output logic [WORD_W-1:0] rd_word
);

  localparam int unsigned IDX_W = $clog2(FRAMES);
  localparam int unsigned CNT_W = $clog2(FRAMES + 1);

  subframe_t         sub;
  logic              accept;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_bit;
  logic              commit;
  logic [CNT_W-1:0]  frame_cnt;
  logic [FRAMES-1:0] stage;
  logic [FRAMES-1:0] held;

  // The capture never stalls the stream
  assign sub_ready = 1'b1;
  assign accept    = sub_valid && sub_ready;
  assign sub       = '{is_b: sub_is_b, blk_start: sub_blk_start, cs_bit: sub_cs_bit};

  cs_frame_tracker #(.FRAMES(FRAMES)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .sub       (sub),
    .chan_sel  (chan_sel),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_bit    (wr_bit),
    .commit    (commit),
    .frame_cnt (frame_cnt)
  );

  cs_stage_reg #(.FRAMES(FRAMES)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_bit (wr_bit),
    .stage  (stage)
  );

  cs_read_port #(.FRAMES(FRAMES), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .stage    (stage),
    .word_sel (word_sel),
    .held     (held),
    .rd_word  (rd_word)
  );

endmodule

// File: rtl/cs_capture_chk.sv
module cs_capture_chk #(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sub_valid,
  input logic              sub_ready,
  input logic              sub_is_b,
  input logic              chan_sel,
  input logic [SEL_W-1:0]  word_sel,
  input logic [WORD_W-1:0] rd_word,
  input logic              commit,
  input logic [CNT_W-1:0]  frame_cnt,
  input logic [FRAMES-1:0] stage,
  input logic [FRAMES-1:0] held
);

  localparam int unsigned NUM_WORDS = FRAMES / WORD_W;

  assert_ready_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ready);

  assert_high_sel_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_sel >= SEL_W'(NUM_WORDS)) |=> (rd_word == '0));

  assert_other_chan_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && (sub_is_b != chan_sel)) |=> $stable(stage));

  assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_valid) |=> $stable(stage));

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= CNT_W'(FRAMES));

  assert_chan_change_abandons_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sel != $past(chan_sel)) |=> (frame_cnt == '0));

  assert_buffer_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit) |=> $stable(held));

endmodule

bind cs_capture cs_capture_chk #(
  .FRAMES (FRAMES),
  .WORD_W (WORD_W),
  .SEL_W  (SEL_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sub_valid (sub_valid),
  .sub_ready (sub_ready),
  .sub_is_b  (sub_is_b),
  .chan_sel  (chan_sel),
  .word_sel  (word_sel),
  .rd_word   (rd_word),
  .commit    (commit),
  .frame_cnt (frame_cnt),
  .stage     (stage),
  .held      (held)
);

// File: tb/sim_cs_capture.sv
`timescale 1ns/1ps
module sim_cs_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_valid = 1'b0;
  logic        sub_ready;
  logic        sub_is_b = 1'b0;
  logic        sub_blk_start = 1'b0;
  logic        sub_cs_bit = 1'b0;
  logic        chan_sel = 1'b0;
  logic [2:0]  word_sel = 3'd0;
  logic [31:0] rd_word;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cs_capture u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .sub_valid     (sub_valid),
    .sub_ready     (sub_ready),
    .sub_is_b      (sub_is_b),
    .sub_blk_start (sub_blk_start),
    .sub_cs_bit    (sub_cs_bit),
    .chan_sel      (chan_sel),
    .word_sel      (word_sel),
    .rd_word       (rd_word)
  );

  function automatic logic pat(int unsigned seed, int unsigned k);
    logic [31:0] x;
    x = (k * 32'h9E3779B1) ^ (seed * 32'h85EBCA6B) ^ (k << 5);
    x = x ^ (x >> 15);
    return x[9];
  endfunction

  function automatic logic [191:0] blk(int unsigned seed);
    logic [191:0] r;
    for (int k = 0; k < 192; k++) r[k] = pat(seed, k);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge
  task automatic send_sub(logic isb, logic st, logic b);
    sub_valid = 1'b1; sub_is_b = isb; sub_blk_start = st; sub_cs_bit = b;
    @(negedge clk);
    sub_valid = 1'b0; sub_blk_start = 1'b0;
  endtask

  task automatic send_frame(logic st, logic a_bit, logic b_bit);
    send_sub(1'b0, st, a_bit);
    send_sub(1'b1, st, b_bit);
  endtask

  // Idle cycle with junk on the other subframe inputs (R8)
  task automatic idle_junk();
    sub_valid = 1'b0; sub_blk_start = 1'b1; sub_cs_bit = 1'b1;
    @(negedge clk);
    sub_blk_start = 1'b0;
  endtask

  // Reads all eight selects; rd_word due one rising edge after word_sel
  task automatic check_buffer(string req, logic [191:0] exp);
    for (int w = 0; w < 8; w++) begin
      word_sel = 3'(w);
      @(negedge clk);
      if (w < 6) check(req, rd_word, exp[32*w +: 32]);
      else       check({req, " R2 high select"}, rd_word, 32'h0);
    end
  endtask

  task automatic test_reset();
    check("R1 R8 ready", {31'd0, sub_ready}, 32'd1);
    check_buffer("R1 reset", 192'd0);
  endtask

  task automatic test_pre_start();
    for (int k = 0; k < 20; k++) send_frame(1'b0, 1'b1, 1'b1);
    check_buffer("R6 frames before start", 192'd0);
  endtask

  task automatic test_full_a();
    chan_sel = 1'b0;
    for (int k = 0; k < 192; k++) begin
      send_frame(k == 0, pat(1, k), pat(2, k));
      if (k % 37 == 5) idle_junk();
    end
    for (int k = 0; k < 5; k++) send_frame(1'b0, ~pat(1, k), 1'b0);
    send_frame(1'b1, 1'b0, 1'b0);
    check_buffer("R2 R3 R4 R6 R8 block A", blk(1));
  endtask

  task automatic test_full_b();
    chan_sel = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 192; k++) send_frame(k == 0, pat(4, k), pat(3, k));
    send_frame(1'b1, 1'b1, 1'b0);
    check_buffer("R3 R4 block B", blk(3));
  endtask

  task automatic test_short();
    for (int k = 0; k < 100; k++) send_frame(k == 0, pat(6, k), pat(5, k));
    send_frame(1'b1, 1'b0, 1'b1);
    check_buffer("R5 short block kept old", blk(3));
  endtask

  task automatic test_chan_switch();
    for (int k = 0; k < 120; k++) send_frame(k == 0, pat(8, k), pat(7, k));
    chan_sel = 1'b0;
    @(negedge clk);
    for (int k = 120; k < 192; k++) send_frame(1'b0, pat(9, k), pat(7, k));
    send_frame(1'b1, 1'b0, 1'b0);
    check_buffer("R7 R9 switch abandons block", blk(3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_pre_start();
    test_full_a();
    test_full_b();
    test_short();
    test_chan_switch();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule